// File: doc/BRIEF.md
# Boot-block flash protection controller

This block decides whether a byte-program or whole-block-erase request may start on a 512 KB flash array. The array has seven erase blocks: a 16 KB boot block, two 8 KB parameter blocks, one 96 KB main block and three 128 KB main blocks. The block decodes the target block from the byte address, using a strap that places the boot block at the top or at the bottom of the map. It checks the programming-supply flag and the boot-block unlock condition, then runs a busy timer that stands in for the internal program/erase sequencer. Three sticky error bits record why an operation was refused or cut short.

A host raises `req_valid` for one cycle with the address and the operation type. The block reports acceptance with a one-cycle `start_ack`, holds `ready` low while the operation runs and raises a one-cycle `done` when it completes. The boot-block unlock condition is either the high-voltage flag on the reset pin or the write-protect pin driven high. It must hold for the whole of a boot-block operation, or the operation is aborted. Taking `rst_n` low acts as power-down: it clears status and cancels any operation in progress.

Top module: `bootflash_guard`

## Requirements
- R1: With `boot_top`=0, `tgt_block` decodes `req_addr` as: 0x00000-0x03FFF → 0 (boot), 0x04000-0x05FFF → 1, 0x06000-0x07FFF → 2, 0x08000-0x1FFFF → 3, 0x20000-0x3FFFF → 4, 0x40000-0x5FFFF → 5, 0x60000-0x7FFFF → 6.
- R2: With `boot_top`=1 the map is mirrored: `tgt_block` equals the R1 decode of the bitwise-inverted address, so 0x7C000-0x7FFFF is block 0 and 0x00000-0x1FFFF is block 6.
- R3: A request with `vpp_ok`=0 while ready does not start: `start_ack` stays 0, `ready` stays 1, and `err_vpp` is 1 from the cycle after the request.
- R4: A request to block 0 with `vpp_ok`=1 but neither `unlock_hv` nor `wp_pin` high does not start. It sets `err_prog` for a program (`req_erase`=0) or `err_erase` for an erase (`req_erase`=1).
- R5: A request to blocks 1 to 6 with `vpp_ok`=1 starts regardless of `unlock_hv` and `wp_pin`. A block-0 request starts when either of them is high.
- R6: After an accepted request sampled at edge E0, `ready` is 0 from E0 until edge E0+N, where N is PROG_CYC for a program and ERASE_CYC for an erase. `done` is 1 for exactly the one cycle after edge E0+N.
- R7: If both `unlock_hv` and `wp_pin` are low at an edge during a block-0 operation, the operation ends at that edge without `done`, `ready` returns to 1, and `err_prog` or `err_erase` is set according to the operation type.
- R8: Requests while `ready` is 0 are ignored: no `start_ack`, no error bit change, and the running operation's completion time is unchanged.
- R9: `rst_n` sampled low clears all three error bits, returns `ready` to 1, cancels any operation in progress, and no `done` follows the cancelled operation.
- R10: Each error bit, once set, stays set until `rst_n` is sampled low.
- R11: `start_ack` is 1 for exactly the one cycle after the edge that accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset / power-down |
| req_valid | input | 1 | Program or erase request strobe |
| req_erase | input | 1 | 1 = block erase, 0 = byte program |
| req_addr | input | 19 | Byte address of the request |
| vpp_ok | input | 1 | Programming supply is valid |
| unlock_hv | input | 1 | Unlock high voltage present on the reset pin |
| wp_pin | input | 1 | Write-protect pin level (high unlocks the boot block) |
| boot_top | input | 1 | 1 = boot block at the top of the map |
| tgt_block | output | 3 | Decoded block index of `req_addr` (0 = boot) |
| ready | output | 1 | No operation running |
| start_ack | output | 1 | One-cycle pulse: request accepted |
| done | output | 1 | One-cycle pulse: operation completed |
| err_vpp | output | 1 | Sticky: start attempted without programming supply |
| err_prog | output | 1 | Sticky: program refused or aborted |
| err_erase | output | 1 | Sticky: erase refused or aborted |

## Verification
The assertions assume that the supply and unlock flags are clean digital levels, sampled on the clock, and that a request lasts a single cycle. They also assume that `req_erase` and `req_addr` are stable in the cycle a request is sampled. The stimulus drives every input on the falling edge and pulses `req_valid` for exactly one rising edge. It keeps the unlock flags steady through a boot-block operation except in the abort case, where they drop once and stay low. Completion latencies are predicted from the cycle counts and matched against observed `start_ack`/`done` pairs by a queue-based scoreboard.

// File: rtl/bfg_pkg.sv
// Package: shared types and address-map helpers for the boot-block
// protection controller. Assumes a seven-block map ordered outward from
// the boot block: boot, two parameter blocks, one short main block and
// three full main blocks.
package bfg_pkg;

    typedef logic [2:0] blk_t;

    localparam blk_t BOOT_BLK  = 3'd0;
    localparam int   NUM_BLK   = 7;
    localparam int   NUM_LIMIT = NUM_BLK - 1;

    // Byte offset (from the boot end of the map) where block g+1 begins.
    function automatic int unsigned blk_limit(input int g, input int boot_kb,
                                              input int param_kb, input int main0_kb,
                                              input int main_kb);
        int unsigned kb;
        if (g < 1)
            kb = boot_kb;
        else if (g < 3)
            kb = boot_kb + g * param_kb;
        else
            kb = boot_kb + 2 * param_kb + main0_kb + (g - 3) * main_kb;
        return kb * 1024;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bfg_block_map.sv
// Block decoder: turns a byte address into a block index, 0 being the boot
// block. Assumes the map is contiguous from the boot end; a top-boot strap
// mirrors it by inverting the address before comparison.
module bfg_block_map
    import bfg_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int BOOT_KB  = 16,
    parameter int PARAM_KB = 8,
    parameter int MAIN0_KB = 96,
    parameter int MAIN_KB  = 128
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              top_strap,
    output blk_t              blk
);

    localparam int LIM_W = ADDR_W + 1;

    logic [ADDR_W-1:0] ofs;
    logic [NUM_LIMIT-1:0] past_lim;

    // Offset measured from the boot end of the map.
    assign ofs = top_strap ? ~addr : addr;

    // One comparator per block boundary.
    for (genvar g = 0; g < NUM_LIMIT; g++) begin : g_lim
        localparam logic [LIM_W-1:0] LIM =
            LIM_W'(blk_limit(g, BOOT_KB, PARAM_KB, MAIN0_KB, MAIN_KB));
        assign past_lim[g] = ({1'b0, ofs} >= LIM);
    end

    // Block index is the number of boundaries the offset has crossed.
    always_comb begin
        blk = '0;
        for (int i = 0; i < NUM_LIMIT; i++)
            blk = blk + blk_t'(past_lim[i]);
    end

    always_comb begin
        AST_BLK_RANGE: assert (blk < blk_t'(NUM_BLK)); // R1
    end

endmodule

// File: rtl/bfg_op_timer.sv
// Busy timer standing in for the program/erase sequencer. Loads a cycle
// count on start, counts down, and pulses done when it runs out. Assumes
// start is only raised while idle; abort ends the operation silently.
module bfg_op_timer
    import bfg_pkg::*;
#(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_erase,
    input  logic abort,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(max2(PROG_CYC, ERASE_CYC) + 1);

    logic [CNT_W-1:0] remain;

    // Run the countdown and produce the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                remain <= start_erase ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
            end else if (busy) begin
                if (abort) begin
                    busy <= 1'b0;
                end else if (remain == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (!busy && !done)); // R7

endmodule

// File: rtl/bfg_status.sv
// Sticky error status: three flags that set on request and clear only on
// reset / power-down. Assumes set strobes are single-cycle.
module bfg_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_vpp,
    input  logic set_prog,
    input  logic set_erase,
    output logic err_vpp,
    output logic err_prog,
    output logic err_erase
);

    // Accumulate error flags until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_vpp   <= 1'b0;
            err_prog  <= 1'b0;
            err_erase <= 1'b0;
        end else begin
            err_vpp   <= err_vpp   | set_vpp;
            err_prog  <= err_prog  | set_prog;
            err_erase <= err_erase | set_erase;
        end
    end

    AST_VPP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_vpp |=> err_vpp); // R10
    AST_PROG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_prog |=> err_prog); // R10
    AST_ERASE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_erase |=> err_erase); // R10

endmodule

// File: rtl/bootflash_guard.sv
// Top: gatekeeper for program and erase requests on a seven-block array.
// Decodes the target block, checks supply and boot-block unlock, starts the
// busy timer and records refusals and aborts in sticky status. Assumes
// rst_n doubles as the power-down input and that requests are one cycle.
module bootflash_guard
    import bfg_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int BOOT_KB   = 16,
    parameter int PARAM_KB  = 8,
    parameter int MAIN0_KB  = 96,
    parameter int MAIN_KB   = 128,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              vpp_ok,
    input  logic              unlock_hv,
    input  logic              wp_pin,
    input  logic              boot_top,
    output logic [2:0]        tgt_block,
    output logic              ready,
    output logic              start_ack,
    output logic              done,
    output logic              err_vpp,
    output logic              err_prog,
    output logic              err_erase
);

    blk_t blk;
    logic busy;
    logic unlocked;
    logic take_req;
    logic is_boot;
    logic fail_vpp;
    logic fail_lock;
    logic go;
    logic abort;
    logic op_erase_q;
    logic op_boot_q;
    logic set_prog;
    logic set_erase;

    bfg_block_map #(
        .ADDR_W  (ADDR_W),
        .BOOT_KB (BOOT_KB),
        .PARAM_KB(PARAM_KB),
        .MAIN0_KB(MAIN0_KB),
        .MAIN_KB (MAIN_KB)
    ) u_map (
        .addr     (req_addr),
        .top_strap(boot_top),
        .blk      (blk)
    );

    // Admission decision for a request arriving while idle.
    assign unlocked  = unlock_hv | wp_pin;
    assign take_req  = req_valid & ~busy;
    assign is_boot   = (blk == BOOT_BLK);
    assign fail_vpp  = take_req & ~vpp_ok;
    assign fail_lock = take_req & vpp_ok & is_boot & ~unlocked;
    assign go        = take_req & vpp_ok & ~(is_boot & ~unlocked);

    // Boot-block operations are cut short when the unlock condition drops.
    assign abort     = busy & op_boot_q & ~unlocked;
    assign set_prog  = (fail_lock & ~req_erase) | (abort & ~op_erase_q);
    assign set_erase = (fail_lock &  req_erase) | (abort &  op_erase_q);

    // Remember the kind and target class of the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_erase_q <= 1'b0;
            op_boot_q  <= 1'b0;
            start_ack  <= 1'b0;
        end else begin
            start_ack <= go;
            if (go) begin
                op_erase_q <= req_erase;
                op_boot_q  <= is_boot;
            end
        end
    end

    bfg_op_timer #(
        .PROG_CYC (PROG_CYC),
        .ERASE_CYC(ERASE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (go),
        .start_erase(req_erase),
        .abort      (abort),
        .busy       (busy),
        .done       (done)
    );

    bfg_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vpp  (fail_vpp),
        .set_prog (set_prog),
        .set_erase(set_erase),
        .err_vpp  (err_vpp),
        .err_prog (err_prog),
        .err_erase(err_erase)
    );

    assign tgt_block = blk;
    assign ready     = ~busy;

    AST_VPP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |-> $past(vpp_ok)); // R3
    AST_BOOT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ack && op_boot_q) |-> $past(unlock_hv || wp_pin)); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |-> (!ready && $past(ready))); // R11
    AST_ABORT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && op_boot_q && !unlock_hv && !wp_pin) |=> (ready && !done && (err_prog || err_erase))); // R7

endmodule

// File: tb/sim_bootflash_guard.sv
module sim_bootflash_guard;

    localparam int P = 8;
    localparam int E = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;
    logic [18:0] req_addr = '0;
    logic        vpp_ok = 1'b0;
    logic        unlock_hv = 1'b0;
    logic        wp_pin = 1'b0;
    logic        boot_top = 1'b0;
    logic [2:0]  tgt_block;
    logic        ready, start_ack, done, err_vpp, err_prog, err_erase;

    int nchk = 0;
    int nerr = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    bootflash_guard #(.PROG_CYC(P), .ERASE_CYC(E)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .vpp_ok(vpp_ok), .unlock_hv(unlock_hv), .wp_pin(wp_pin),
        .boot_top(boot_top), .tgt_block(tgt_block), .ready(ready), .start_ack(start_ack),
        .done(done), .err_vpp(err_vpp), .err_prog(err_prog), .err_erase(err_erase)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One-edge request; returns at the falling edge after the sampling edge.
    task automatic request(input logic [18:0] a, input logic er, input logic v,
                           input logic hv, input logic wp);
        req_addr = a; req_erase = er; vpp_ok = v; unlock_hv = hv; wp_pin = wp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_ready;
        while (ready !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Scoreboard monitor: measures start_ack-to-done latency against the queue.
    int  mon_cnt = 0;
    bit  mon_active = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_ack) begin
                if (mon_active) begin nchk++; nerr++; $display("FAIL R11: actual ack while active expected none"); end
                mon_active = 1; mon_cnt = 0;
            end else if (mon_active) begin
                mon_cnt++;
                if (done) begin
                    mon_active = 0;
                    if (exp_q.size() == 0) check("R6 unexpected done", 1, 0);
                    else check("R6 latency", mon_cnt, exp_q.pop_front());
                end else if (ready) begin
                    mon_active = 0;
                end
            end
        end else begin
            mon_active = 0;
        end
    end

    initial begin
        #(20 * 100000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [18:0] bot_a [10] = '{19'h00000, 19'h03FFF, 19'h04000, 19'h05FFF, 19'h06000,
                                     19'h08000, 19'h1FFFF, 19'h20000, 19'h40000, 19'h7FFFF};
        int          bot_b [10] = '{0, 0, 1, 1, 2, 3, 3, 4, 5, 6};
        logic [18:0] top_a [6]  = '{19'h7FFFF, 19'h7C000, 19'h7BFFF, 19'h60000, 19'h5FFFF, 19'h00000};
        int          top_b [6]  = '{0, 0, 1, 3, 4, 6};

        @(negedge clk);
        do_reset();
        // R9: reset state
        check("R9 ready after reset", ready, 1);
        check("R9 status after reset", {err_vpp, err_prog, err_erase, done, start_ack}, 0);

        // R1 / R2: address map both ways
        for (int i = 0; i < 10; i++) begin
            boot_top = 1'b0; req_addr = bot_a[i]; #1;
            check("R1 bottom map", tgt_block, bot_b[i]);
        end
        for (int i = 0; i < 6; i++) begin
            boot_top = 1'b1; req_addr = top_a[i]; #1;
            check("R2 top map", tgt_block, top_b[i]);
        end
        boot_top = 1'b0;
        @(negedge clk);

        // R5 / R11 / R6: program a main block without unlock
        exp_q.push_back(P);
        request(19'h30000, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R11 ack raised", start_ack, 1);
        check("R5 main accepted, busy", ready, 0);
        @(negedge clk);
        check("R11 ack one cycle", start_ack, 0);
        wait_ready();
        check("R6 no errors after program", {err_vpp, err_prog, err_erase}, 0);

        // R6 / R5: erase a parameter block
        exp_q.push_back(E);
        request(19'h05000, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 param erase accepted", start_ack, 1);
        wait_ready();

        // R3: missing supply
        request(19'h10000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 no ack", start_ack, 0);
        check("R3 still ready", ready, 1);
        check("R3 vpp error", {err_vpp, err_prog, err_erase}, 3'b100);

        // R10: error stays through a good operation
        exp_q.push_back(P);
        request(19'h50000, 1'b0, 1'b1, 1'b0, 1'b0);
        wait_ready();
        check("R10 vpp error sticky", err_vpp, 1);
        do_reset();
        check("R9 reset clears status", {err_vpp, err_prog, err_erase}, 0);

        // R4: locked boot block, program then erase
        request(19'h00100, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 locked program refused", {start_ack, ready}, 2'b01);
        check("R4 program error", {err_vpp, err_prog, err_erase}, 3'b010);
        request(19'h03000, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 locked erase refused", {start_ack, ready}, 2'b01);
        check("R4 erase error", {err_vpp, err_prog, err_erase}, 3'b011);
        do_reset();

        // R5: boot block unlocked by write-protect pin, then top-boot via high voltage
        exp_q.push_back(P);
        request(19'h00100, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R5 boot program via wp", start_ack, 1);
        wait_ready();
        boot_top = 1'b1;
        exp_q.push_back(E);
        request(19'h7F000, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R5 top boot erase via hv", start_ack, 1);
        wait_ready();
        boot_top = 1'b0;
        check("R5 no errors", {err_vpp, err_prog, err_erase}, 0);

        // R7: unlock dropped mid-erase on boot block
        request(19'h00000, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R7 boot erase started", start_ack, 1);
        repeat (3) @(negedge clk);
        wp_pin = 1'b0;
        @(negedge clk);
        check("R7 aborted, ready", ready, 1);
        check("R7 no done on abort", done, 0);
        check("R7 erase error set", {err_vpp, err_prog, err_erase}, 3'b001);
        do_reset();

        // R8: request while busy is ignored
        exp_q.push_back(P);
        request(19'h60000, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        request(19'h08000, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 no ack while busy", start_ack, 0);
        check("R8 no error while busy", {err_vpp, err_prog, err_erase}, 0);
        vpp_ok = 1'b1;
        wait_ready();
        check("R8 queue drained", exp_q.size(), 0);

        // R9: reset cancels a running erase
        request(19'h10000, 1'b0, 1'b0, 1'b0, 1'b0);
        exp_q.push_back(E);
        request(19'h10000, 1'b1, 1'b1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        check("R9 ready after cancel", ready, 1);
        check("R9 status cleared", {err_vpp, err_prog, err_erase}, 0);
        begin
            logic seen = 1'b0;
            for (int i = 0; i < E + 4; i++) begin
                @(negedge clk);
                seen = seen | done;
            end
            check("R9 no done after cancel", seen, 0);
        end

        check("R6 scoreboard empty", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule